// File: doc/BRIEF.md
# Thread Block Dispatcher with Residency Limits

This block takes a stream of launch requests, each naming a thread block and its thread count, and places every block, whole, onto one of several compute-unit slots. Each slot keeps two running totals, resident blocks and resident threads. A block goes to a slot only when both totals stay within their caps after adding it. When a slot later reports that a block has finished, it hands back one block and the threads that block used.

Requests enter through a valid/ready port into a small in-order queue. The head of the queue is looked at once per cycle. A size that can never be legal is dropped with a one-cycle error pulse. A legal block goes out on a registered valid/ready port with its identifier, the chosen slot and its warp count. If no slot can take the head block, the dispatcher waits. Slots are searched round-robin, starting just after the slot used last.

Top module: `tbd_dispatch`

## Requirements
- R1: A request whose thread count is 0 or above 512 raises `err_flag` for exactly one cycle, one cycle after it reaches the queue head. It is removed from the queue and never dispatched. Counts 1 to 512 inclusive are legal.
- R2: A slot never holds more than 8 resident blocks. With 64-thread blocks and 4 slots, exactly 32 blocks are placed before the next one waits.
- R3: A slot never holds more than 768 resident threads. A block is placed only if the slot's thread total plus the block's size is at most 768. With 256-thread blocks and 4 slots, 12 blocks are placed before the next one waits.
- R4: Each legal block is dispatched exactly once, to a single slot index below the slot count. The slot is the first one that fits, searching upward with wrap-around from the slot after the last one used. After reset the search starts at slot 0.
- R5: Requests are handled strictly in arrival order. While the head block cannot be placed, nothing behind it is dispatched or rejected.
- R6: `disp_warps` equals the thread count divided by 32, rounded up: 1 thread gives 1, 32 gives 1, 33 gives 2, 512 gives 16.
- R7: A cycle with `cpl_valid` high takes one block and `cpl_threads` threads away from slot `cpl_sm` in that cycle. A waiting head block that then fits is dispatched without further stimulus.
- R8: While `disp_valid` is high and `disp_ready` is low, `disp_valid`, `disp_id`, `disp_sm` and `disp_warps` hold their values.
- R9: After reset `disp_valid` and `err_flag` are low, `req_ready` is high, and every slot is empty.
- R10: The request queue accepts a request on a cycle where `req_valid` and `req_ready` are both high. It lowers `req_ready` when full and loses no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Launch request present |
| req_ready | output | 1 | Queue can take a request |
| req_id | input | 8 | Block identifier |
| req_threads | input | 11 | Thread count of the block |
| disp_valid | output | 1 | Dispatch present |
| disp_ready | input | 1 | Consumer accepts dispatch |
| disp_id | output | 8 | Identifier of the dispatched block |
| disp_sm | output | 2 | Slot chosen for the block |
| disp_warps | output | 5 | Warp count of the block |
| err_flag | output | 1 | One-cycle pulse for a rejected size |
| cpl_valid | input | 1 | A resident block has finished |
| cpl_sm | input | 2 | Slot reporting the finish |
| cpl_threads | input | 11 | Threads released by the finish |

## Verification
Assertions check on every cycle that no slot goes past its block or thread cap and that every placement lands on a slot that fits. They also check that a completion never releases more than a slot holds, that a held dispatch stays stable, and that an error pulse never shares a cycle with a dispatch. The bench scenarios show the rest: the exact round-robin slot order, the warp arithmetic at its edges, the 32-block and 12-block saturation points, head-of-line waiting with an illegal request queued behind, and release after one or two completions. These depend on request order and history, which per-cycle properties cannot see.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    localparam int unsigned SM_COUNT    = 4;
    localparam int unsigned BLK_LIMIT   = 8;
    localparam int unsigned THR_LIMIT   = 768;
    localparam int unsigned BLK_THR_MAX = 512;
    localparam int unsigned WARP_SIZE   = 32;
    localparam int unsigned ID_BITS     = 8;
    localparam int unsigned REQ_BITS    = 11;
    localparam int unsigned Q_DEPTH     = 4;

    typedef enum logic [1:0] {
        VERDICT_WAIT,
        VERDICT_REJECT,
        VERDICT_PLACE
    } verdict_e;
endpackage

// File: rtl/tbd_req_fifo.sv
module tbd_req_fifo #(
    parameter int unsigned W     = 19,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_pop
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push;

    assign in_ready  = (st_q.cnt != FULL_CNT);
    assign out_valid = (st_q.cnt != '0);
    assign out_data  = mem_q[st_q.rd];
    assign push      = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
        end
        if (out_pop) begin
            st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, out_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[st_q.wr] <= in_data;
        end
    end

    a_r10_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        out_pop |-> out_valid);
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT);
    a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT && !out_pop) |=> st_q.cnt == FULL_CNT);
endmodule

// File: rtl/tbd_sm_slot.sv
module tbd_sm_slot #(
    parameter int unsigned BLK_LIMIT = 8,
    parameter int unsigned THR_LIMIT = 768,
    parameter int unsigned REQ_BITS  = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REQ_BITS-1:0] probe_thr,
    output logic                fits,
    input  logic                add_en,
    input  logic                sub_en,
    input  logic [REQ_BITS-1:0] sub_thr
);
    localparam int unsigned BLK_W = $clog2(BLK_LIMIT + 1);
    localparam int unsigned THR_W = $clog2(THR_LIMIT + 1);
    localparam int unsigned SUM_W = ((THR_W > REQ_BITS) ? THR_W : REQ_BITS) + 1;
    localparam logic [BLK_W-1:0] BLK_CAP = BLK_W'(BLK_LIMIT);
    localparam logic [SUM_W-1:0] THR_CAP = SUM_W'(THR_LIMIT);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [THR_W-1:0] thr;
    } slot_st_t;

    slot_st_t st_d, st_q;
    logic [SUM_W-1:0] thr_wide;
    logic [SUM_W-1:0] probe_sum;
    logic [SUM_W-1:0] thr_next;

    assign thr_wide  = SUM_W'(st_q.thr);
    assign probe_sum = thr_wide + SUM_W'(probe_thr);
    assign fits      = (st_q.blk < BLK_CAP) && (probe_sum <= THR_CAP);

    always_comb begin
        st_d     = st_q;
        thr_next = thr_wide;
        if (add_en) begin
            thr_next = thr_next + SUM_W'(probe_thr);
        end
        if (sub_en) begin
            thr_next = thr_next - SUM_W'(sub_thr);
        end
        st_d.thr = THR_W'(thr_next);
        case ({add_en, sub_en})
            2'b10:   st_d.blk = st_q.blk + 1'b1;
            2'b01:   st_d.blk = st_q.blk - 1'b1;
            default: st_d.blk = st_q.blk;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    a_r2_block_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.blk <= BLK_CAP);
    a_r3_thread_cap: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wide <= THR_CAP);
    a_r3_place_only_if_fits: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |-> fits);
    a_r7_release_covered: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en |-> (st_q.blk != '0) && (thr_wide >= SUM_W'(sub_thr)));
    a_r7_release_block: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && !add_en) |=> st_q.blk == $past(st_q.blk) - 1'b1);
endmodule

// File: rtl/tbd_rr_pick.sv
module tbd_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned SW = 2
) (
    input  logic [N-1:0]  fit,
    input  logic [SW-1:0] last,
    output logic          found,
    output logic [SW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = 1; off <= int'(N); off++) begin
            int cand;
            cand = int'(last) + off;
            if (cand >= int'(N)) begin
                cand = cand - int'(N);
            end
            if (!found && fit[cand]) begin
                found = 1'b1;
                idx   = SW'(cand);
            end
        end
    end

    always_comb begin
        if (found) begin
            a_r4_pick_fits: assert (fit[idx]);
        end
        if (fit != '0) begin
            a_r4_pick_when_any: assert (found);
        end
    end
endmodule

// File: rtl/tbd_dispatch.sv
module tbd_dispatch
    import tbd_pkg::*;
#(
    parameter int unsigned N_SM     = SM_COUNT,
    parameter int unsigned MAX_BLK  = BLK_LIMIT,
    parameter int unsigned MAX_THR  = THR_LIMIT,
    parameter int unsigned BLK_MAX  = BLK_THR_MAX,
    parameter int unsigned WARP     = WARP_SIZE,
    parameter int unsigned IDW      = ID_BITS,
    parameter int unsigned RQW      = REQ_BITS,
    parameter int unsigned QDEPTH   = Q_DEPTH,
    localparam int unsigned SMW     = (N_SM > 1) ? $clog2(N_SM) : 1,
    localparam int unsigned WARP_W  = $clog2(BLK_MAX / WARP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDW-1:0]    req_id,
    input  logic [RQW-1:0]    req_threads,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [IDW-1:0]    disp_id,
    output logic [SMW-1:0]    disp_sm,
    output logic [WARP_W-1:0] disp_warps,
    output logic              err_flag,
    input  logic              cpl_valid,
    input  logic [SMW-1:0]    cpl_sm,
    input  logic [RQW-1:0]    cpl_threads
);
    localparam int unsigned QW      = IDW + RQW;
    localparam int unsigned WSHIFT  = $clog2(WARP);
    localparam logic [RQW-1:0] SIZE_CAP  = RQW'(BLK_MAX);
    localparam logic [RQW:0]   WARP_PAD  = (RQW + 1)'(WARP - 1);
    localparam logic [SMW-1:0] LAST_INIT = SMW'(N_SM - 1);

    typedef struct packed {
        logic              dvld;
        logic [IDW-1:0]    did;
        logic [SMW-1:0]    dsm;
        logic [WARP_W-1:0] dwarps;
        logic              err;
        logic [SMW-1:0]    last;
    } disp_st_t;

    disp_st_t st_d, st_q;

    logic           head_vld;
    logic [QW-1:0]  head_data;
    logic [IDW-1:0] head_id;
    logic [RQW-1:0] head_thr;
    logic           head_pop;
    logic           legal;
    logic           out_free;
    logic [N_SM-1:0] fit_vec;
    logic           pick_found;
    logic [SMW-1:0] pick_idx;
    logic [RQW:0]   warp_sum;
    verdict_e       verdict;

    tbd_req_fifo #(
        .W     (QW),
        .DEPTH (QDEPTH)
    ) i_req_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_data   ({req_id, req_threads}),
        .out_valid (head_vld),
        .out_data  (head_data),
        .out_pop   (head_pop)
    );

    assign head_id  = head_data[QW-1:RQW];
    assign head_thr = head_data[RQW-1:0];
    assign legal    = (head_thr != '0) && (head_thr <= SIZE_CAP);
    assign out_free = !st_q.dvld || disp_ready;
    assign warp_sum = {1'b0, head_thr} + WARP_PAD;

    for (genvar g = 0; g < N_SM; g++) begin : g_slot
        logic add_here;
        logic sub_here;
        assign add_here = (verdict == VERDICT_PLACE) && (pick_idx == SMW'(g));
        assign sub_here = cpl_valid && (cpl_sm == SMW'(g));

        tbd_sm_slot #(
            .BLK_LIMIT (MAX_BLK),
            .THR_LIMIT (MAX_THR),
            .REQ_BITS  (RQW)
        ) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .probe_thr (head_thr),
            .fits      (fit_vec[g]),
            .add_en    (add_here),
            .sub_en    (sub_here),
            .sub_thr   (cpl_threads)
        );
    end

    tbd_rr_pick #(
        .N  (N_SM),
        .SW (SMW)
    ) i_pick (
        .fit   (fit_vec),
        .last  (st_q.last),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        verdict = VERDICT_WAIT;
        if (head_vld && out_free) begin
            if (!legal) begin
                verdict = VERDICT_REJECT;
            end else if (pick_found) begin
                verdict = VERDICT_PLACE;
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        head_pop = 1'b0;
        if (st_q.dvld && disp_ready) begin
            st_d.dvld = 1'b0;
        end
        case (verdict)
            VERDICT_REJECT: begin
                head_pop = 1'b1;
                st_d.err = 1'b1;
            end
            VERDICT_PLACE: begin
                head_pop    = 1'b1;
                st_d.dvld   = 1'b1;
                st_d.did    = head_id;
                st_d.dsm    = pick_idx;
                st_d.dwarps = WARP_W'(warp_sum >> WSHIFT);
                st_d.last   = pick_idx;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= LAST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp_valid = st_q.dvld;
    assign disp_id    = st_q.did;
    assign disp_sm    = st_q.dsm;
    assign disp_warps = st_q.dwarps;
    assign err_flag   = st_q.err;

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_id)
            && $stable(disp_sm) && $stable(disp_warps));
    a_r6_warp_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (disp_warps != '0) && (disp_warps <= WARP_W'(BLK_MAX / WARP)));
    a_r4_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> int'(disp_sm) < int'(N_SM));
    a_r1_reject_alone: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |-> !disp_valid);
    a_r5_wait_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (head_vld && verdict == VERDICT_WAIT) |=> head_vld && $stable(head_data));
endmodule

// File: tb/test_tbd_dispatch.sv
module test_tbd_dispatch;
    localparam int NSM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_id = '0;
    logic [10:0] req_threads = '0;
    logic        disp_valid;
    logic        disp_ready;
    logic [7:0]  disp_id;
    logic [1:0]  disp_sm;
    logic [4:0]  disp_warps;
    logic        err_flag;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_sm = '0;
    logic [10:0] cpl_threads = '0;

    always #4 clk = ~clk;

    tbd_dispatch i_tbd_dispatch (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_id      (req_id),
        .req_threads (req_threads),
        .disp_valid  (disp_valid),
        .disp_ready  (disp_ready),
        .disp_id     (disp_id),
        .disp_sm     (disp_sm),
        .disp_warps  (disp_warps),
        .err_flag    (err_flag),
        .cpl_valid   (cpl_valid),
        .cpl_sm      (cpl_sm),
        .cpl_threads (cpl_threads)
    );

    typedef struct {
        bit is_err;
        int id;
        int sm;
        int warps;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    int   blk_m[NSM];
    int   thr_m[NSM];
    int   last_m = NSM - 1;
    bit   mon_on = 1'b0;
    bit   bp_en  = 1'b0;
    bit   done   = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int model_place(input int id, input int thr);
        for (int off = 1; off <= NSM; off++) begin
            int c;
            c = (last_m + off) % NSM;
            if (blk_m[c] < 8 && thr_m[c] + thr <= 768) begin
                exp_t e;
                blk_m[c]++;
                thr_m[c] += thr;
                last_m = c;
                e.is_err = 1'b0;
                e.id = id;
                e.sm = c;
                e.warps = (thr + 31) / 32;
                exp_q.push_back(e);
                return c;
            end
        end
        return -1;
    endfunction

    task automatic drive_req(input int id, input int thr);
        @(negedge clk);
        req_valid   = 1'b1;
        req_id      = 8'(id);
        req_threads = 11'(thr);
        forever begin
            bit rdy;
            rdy = req_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic complete(input int sm, input int thr);
        @(negedge clk);
        cpl_valid   = 1'b1;
        cpl_sm      = 2'(sm);
        cpl_threads = 11'(thr);
        blk_m[sm]--;
        thr_m[sm] -= thr;
        @(negedge clk);
        cpl_valid = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int s = 0; s < NSM; s++) begin
            int b;
            int t;
            b = blk_m[s];
            t = thr_m[s];
            for (int k = 0; k < b - 1; k++) complete(s, 1);
            if (b > 0) complete(s, t - (b - 1));
        end
    endtask

    task automatic send_req(input int id, input int thr);
        if (thr == 0 || thr > 512) begin
            exp_t e;
            e.is_err = 1'b1;
            e.id = id;
            e.sm = 0;
            e.warps = 0;
            exp_q.push_back(e);
        end else if (model_place(id, thr) < 0) begin
            int r;
            wait_drain();
            clear_all();
            r = model_place(id, thr);
            check(r >= 0, "R3 model refill", r, 0);
        end
        drive_req(id, thr);
    endtask

    task automatic expect_quiet(input int cycles, input string req);
        int seen;
        seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            #1;
            if (disp_valid || err_flag) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on && disp_valid && disp_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected dispatch id", int'(disp_id), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(!e.is_err, "R1 dispatch where reject expected", int'(disp_id), e.id);
                    check(int'(disp_id) == e.id, "R5 dispatch order id", int'(disp_id), e.id);
                    check(int'(disp_sm) == e.sm, "R4 slot choice", int'(disp_sm), e.sm);
                    check(int'(disp_warps) == e.warps, "R6 warp count", int'(disp_warps), e.warps);
                end
            end
            if (mon_on && err_flag) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R1 unexpected error pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.is_err, "R1 error pulse for id", 1, e.id);
                end
            end
        end
    end

    // consumer backpressure
    initial begin
        logic [7:0] lf;
        lf = 8'h5a;
        disp_ready = 1'b1;
        forever begin
            @(negedge clk);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            disp_ready = bp_en ? lf[0] : 1'b1;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NSM; s++) begin
            blk_m[s] = 0;
            thr_m[s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(disp_valid == 1'b0, "R9 disp_valid after reset", int'(disp_valid), 0);
        check(err_flag == 1'b0, "R9 err_flag after reset", int'(err_flag), 0);
        check(req_ready == 1'b1, "R9 req_ready after reset", int'(req_ready), 1);
        mon_on = 1'b1;

        // R2: 64-thread blocks saturate the block cap (32 placed)
        for (int i = 0; i < 32; i++) send_req(i, 64);
        wait_drain();
        drive_req(40, 64);
        expect_quiet(20, "R2 block cap stalls 33rd block");
        complete(2, 64);
        check(model_place(40, 64) == 2, "R7 freed slot chosen", 2, 2);
        wait_drain();
        check(exp_q.size() == 0, "R7 waiting block dispatched", exp_q.size(), 0);
        clear_all();

        // R3 and R5: 256-thread blocks saturate the thread cap (12 placed)
        for (int i = 0; i < 12; i++) send_req(50 + i, 256);
        wait_drain();
        drive_req(70, 512);
        drive_req(71, 1000);
        expect_quiet(20, "R5 head blocks illegal request behind it");
        complete(1, 256);
        expect_quiet(10, "R3 512 still exceeds 768 total");
        complete(1, 256);
        check(model_place(70, 512) == 1, "R3 slot 1 after two completions", 1, 1);
        begin
            exp_t e;
            e.is_err = 1'b1;
            e.id = 71;
            e.sm = 0;
            e.warps = 0;
            exp_q.push_back(e);
        end
        wait_drain();
        clear_all();

        // R1 and R6: size edges
        send_req(80, 1);
        send_req(81, 32);
        send_req(82, 33);
        send_req(83, 512);
        send_req(84, 0);
        send_req(85, 513);
        send_req(86, 31);
        send_req(87, 2047);
        send_req(88, 64);
        wait_drain();

        // R8 and R10: backpressure with mixed sizes
        bp_en = 1'b1;
        begin
            logic [15:0] x;
            x = 16'hace1;
            for (int i = 0; i < 30; i++) begin
                x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
                send_req(100 + i, int'(x) % 600);
            end
        end
        wait_drain();
        bp_en = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R10 all queued requests resolved", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule